// File: doc/BRIEF.md
# Four-Lane Q31 Fractional Multiplier

This block is a pipelined SIMD multiplier for a signal-processing datapath. Each operand is a 128-bit word that carries four independent signed 32-bit lanes. A two-bit operation code picks one of three lane operations:

- a plain integer multiply that keeps the low 32 bits of each product;
- a Q31 fractional multiply that rounds, normalises and saturates each product back into a 32-bit fraction;
- a 16-bit mode that multiplies signed halfwords, doubles each product and saturates it to 32 bits.

An operation is presented with `in_valid` and may be issued on every cycle. Its result appears with `out_valid` exactly two clock cycles later. There is no back-pressure, so the consumer must take each result in the cycle it is presented. Lanes never interact: no carry, rounding or saturation event crosses a lane boundary.

Top module: `simd_q31_mul`

## Requirements
- R1: Lane i (i = 0..3) of `in_a`, `in_b` and `out_res` occupies bits [32i+31:32i], and each lane result depends only on the operand lanes it is computed from.
- R2: The operation code `in_op` is decoded as follows: 0 is integer, 1 is fractional, 2 is 16-bit, and 3 is reserved and yields an all-zero result.
- R3: In integer mode each result lane is the low 32 bits of the signed 32x32 product, with no saturation (0x80000000 times 0xFFFFFFFF gives 0x80000000).
- R4: In fractional mode each result lane is (P + 2^30) arithmetically shifted right by 31, where P is the signed 64-bit product, so it rounds half upward. The value 0x80000000 never appears.
- R5: In fractional mode the single overflowing pair, 0x80000000 times 0x80000000, gives 0x7FFFFFFF.
- R6: In 16-bit mode result lane j (j = 0..3) is twice the signed product of the halfwords at bits [16j+15:16j] of `in_a` and `in_b`. Bits [127:64] of both operands are ignored.
- R7: In 16-bit mode the pair -32768 times -32768 saturates to 0x7FFFFFFF.
- R8: A result is presented with `out_valid` high exactly two rising edges after its operation is sampled with `in_valid` high. Operations issued on consecutive cycles give results on consecutive cycles.
- R9: While `rst_n` is low at a rising edge, `out_valid` and `out_res` go to zero and any operation in flight is discarded.
- R10: `out_res` keeps its last value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | Lane operation code |
| in_a | input | 128 | First operand, four 32-bit lanes |
| in_b | input | 128 | Second operand, four 32-bit lanes |
| out_valid | output | 1 | Result present on `out_res` |
| out_res | output | 128 | Four 32-bit lane results |

## Verification
The embedded properties assume that `in_valid` and `in_op` are always known. They also assume that `in_valid` is held low while reset is applied. The latency property is only armed from the second cycle after reset, so it never compares against values sampled during reset. The bench drives all inputs on the falling edge and keeps `in_valid` low throughout reset. It issues every operation code, including the reserved one, with operands that reach both saturation pairs, the rounding tie and the most negative lane values.

// File: rtl/smul_pkg.sv
// Shared definitions for the four-lane multiplier.
// Assumes the operation code is two bits wide.
package smul_pkg;
    typedef enum logic [1:0] {
        SM_INT  = 2'd0,
        SM_FRAC = 2'd1,
        SM_HALF = 2'd2,
        SM_RSV  = 2'd3
    } smul_op_e;
endpackage

// File: rtl/smul_lane_prod.sv
// First pipeline stage of one lane: registers the full signed product of the
// lane words and the signed product of the selected halfword pair.
// Assumes LW is even; products are only captured when en is high.
module smul_lane_prod #(
    parameter int LW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    input  logic [LW/2-1:0] ha,
    input  logic [LW/2-1:0] hb,
    output logic [2*LW-1:0] p_full,
    output logic [LW-1:0]   p_half
);
    localparam int PW = 2 * LW;
    localparam int HW = LW / 2;

    logic signed [PW-1:0] ax, bx;
    logic signed [LW-1:0] hax, hbx;

    // sign-extend the operands to the product width
    always_comb begin
        ax  = {{LW{a[LW-1]}}, a};
        bx  = {{LW{b[LW-1]}}, b};
        hax = {{HW{ha[HW-1]}}, ha};
        hbx = {{HW{hb[HW-1]}}, hb};
    end

    // capture both products when an operation is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_full <= '0;
            p_half <= '0;
        end else if (en) begin
            p_full <= ax * bx;
            p_half <= hax * hbx;
        end
    end

    // R3: a zero operand always yields a zero product
    a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (a == '0 || b == '0)) |=> (p_full == '0));
endmodule

// File: rtl/smul_lane_fmt.sv
// Second pipeline stage of one lane: turns the registered products into the
// 32-bit lane result for the selected operation and holds it between results.
// Assumes p_full and p_half come from smul_lane_prod one cycle earlier.
module smul_lane_fmt
    import smul_pkg::*;
#(
    parameter int LW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_in,
    input  smul_op_e        op,
    input  logic [2*LW-1:0] p_full,
    input  logic [LW-1:0]   p_half,
    output logic [LW-1:0]   res
);
    localparam int PW = 2 * LW;
    localparam logic signed [PW-1:0] RND  = PW'(1) << (LW - 2);
    localparam logic signed [PW-1:0] MAXP = (PW'(1) << (LW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINP = -(PW'(1) << (LW - 1));
    localparam logic [LW-1:0] MAXL = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] MINL = {1'b1, {(LW-1){1'b0}}};

    logic signed [PW-1:0] rnd_sum, shifted;
    logic [LW-1:0] frac_val, half_val, nxt;

    // fractional path: round, normalise, clamp
    always_comb begin
        rnd_sum = $signed(p_full) + RND;
        shifted = rnd_sum >>> (LW - 1);
        if (shifted > MAXP)      frac_val = MAXL;
        else if (shifted < MINP) frac_val = MINL;
        else                     frac_val = shifted[LW-1:0];
    end

    // halfword path: double the product, clamp on sign change
    always_comb begin
        if (p_half[LW-1] != p_half[LW-2])
            half_val = p_half[LW-1] ? MINL : MAXL;
        else
            half_val = {p_half[LW-2:0], 1'b0};
    end

    // pick the result for the lane operation
    always_comb begin
        unique case (op)
            SM_INT:  nxt = p_full[LW-1:0];
            SM_FRAC: nxt = frac_val;
            SM_HALF: nxt = half_val;
            default: nxt = '0;
        endcase
    end

    // register the lane result, holding it when no operation arrives
    always_ff @(posedge clk) begin
        if (!rst_n)    res <= '0;
        else if (v_in) res <= nxt;
    end

    a_r4_frac_no_min: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && op == SM_FRAC) |=> (res != MINL));
    a_r6_half_even: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && op == SM_HALF) |=> (res == MAXL || res[0] == 1'b0));
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && op == SM_RSV) |=> (res == '0));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> $stable(res));
endmodule

// File: rtl/simd_q31_mul.sv
// Four-lane SIMD multiplier with integer, Q31 fractional and doubled
// 16-bit modes. Fixed two-cycle latency, one operation per cycle, no stall.
// Assumes in_valid is low during reset and in_op is always known.
module simd_q31_mul
    import smul_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_op,
    input  logic [LANES*LW-1:0] in_a,
    input  logic [LANES*LW-1:0] in_b,
    output logic                out_valid,
    output logic [LANES*LW-1:0] out_res
);
    localparam int HW = LW / 2;
    localparam int PW = 2 * LW;

    logic     v1;
    smul_op_e op1;
    logic [1:0] warm;

    // stage-one control: valid flag and operation code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1  <= 1'b0;
            op1 <= SM_INT;
        end else begin
            v1 <= in_valid;
            if (in_valid) op1 <= smul_op_e'(in_op);
        end
    end

    // stage-two control: output valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v1;
    end

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            logic [PW-1:0] pf;
            logic [LW-1:0] ph;

            smul_lane_prod #(.LW(LW)) u_prod (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (in_valid),
                .a      (in_a[i*LW +: LW]),
                .b      (in_b[i*LW +: LW]),
                .ha     (in_a[i*HW +: HW]),
                .hb     (in_b[i*HW +: HW]),
                .p_full (pf),
                .p_half (ph)
            );

            smul_lane_fmt #(.LW(LW)) u_fmt (
                .clk    (clk),
                .rst_n  (rst_n),
                .v_in   (v1),
                .op     (op1),
                .p_full (pf),
                .p_half (ph),
                .res    (out_res[i*LW +: LW])
            );
        end
    endgenerate

    // count cycles since reset so the latency check never looks into reset
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/sim_simd_q31_mul.sv
module sim_simd_q31_mul;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = 2'd0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_res;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    simd_q31_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
    );

    localparam int NV = 7;
    // vectors: 0 int, 1-2 frac (R4 R5), 3-4 half (R6 R7), 5 reserved (R2), 6 int (R3)
    localparam logic [1:0] TO [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0};
    localparam logic [127:0] TA [NV] = '{
        128'h7FFFFFFF_00010000_FFFFFFFE_00000003,
        128'h00000001_80000000_80000000_40000000,
        128'h7FFFFFFF_FFFFFFFF_FFFFFFFF_00000001,
        128'hDEADBEEF_12345678_4000FFFE_80000003,
        128'h00000000_00000000_FFFF7FFF_12348000,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'hFFFFFFFF_12345678_80000000_80000000};
    localparam logic [127:0] TB [NV] = '{
        128'h00000002_00010000_00000007_00000005,
        128'h40000000_7FFFFFFF_80000000_40000000,
        128'h7FFFFFFF_40000001_40000000_3FFFFFFF,
        128'hCAFEF00D_87654321_40000005_80000004,
        128'h00000000_00000000_FFFF7FFF_00007FFF,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'hFFFFFFFF_00000000_FFFFFFFF_80000000};
    localparam logic [127:0] TE [NV] = '{
        128'hFFFFFFFE_00000000_FFFFFFF2_0000000F,
        128'h00000001_80000001_7FFFFFFF_20000000,
        128'h7FFFFFFE_FFFFFFFF_00000000_00000000,
        128'h20000000_FFFFFFEC_7FFFFFFF_00000018,
        128'h00000002_7FFE0002_00000000_80010000,
        128'h00000000_00000000_00000000_00000000,
        128'h00000001_00000000_80000000_00000000};
    localparam string TR [NV] = '{"R1 R3", "R4 R5", "R4", "R6 R7", "R6", "R2", "R3"};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset valid", {127'd0, out_valid}, 128'd0);
        chk("R9 reset result", out_res, 128'd0);
        rst_n = 1'b1;

        // table walk: issue one vector per cycle, results two cycles later (R8)
        for (int n = 0; n < NV + 3; n++) begin
            @(negedge clk);
            if (n >= 2 && n < NV + 2) begin
                chk({TR[n-2], " R8 valid"}, {127'd0, out_valid}, 128'd1);
                chk(TR[n-2], out_res, TE[n-2]);
            end
            if (n == NV + 2) begin
                chk("R10 idle valid", {127'd0, out_valid}, 128'd0);
                chk("R10 hold", out_res, TE[NV-1]);
            end
            if (n < NV) begin
                in_valid = 1'b1; in_op = TO[n]; in_a = TA[n]; in_b = TB[n];
            end else begin
                in_valid = 1'b0; in_a = '1; in_b = '1; in_op = 2'd1;
            end
        end

        // R8: single issue, exact latency, one-cycle pulse
        in_valid = 1'b1; in_op = TO[0]; in_a = TA[0]; in_b = TB[0];
        @(negedge clk);
        in_valid = 1'b0; in_a = '0; in_b = '0;
        chk("R8 early", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        chk("R8 on time", {127'd0, out_valid}, 128'd1);
        chk("R8 result", out_res, TE[0]);
        @(negedge clk);
        chk("R8 pulse end", {127'd0, out_valid}, 128'd0);
        // R10: no valid input, result unchanged
        chk("R10 hold after pulse", out_res, TE[0]);

        // R9: reset discards an operation in flight
        in_valid = 1'b1; in_op = TO[1]; in_a = TA[1]; in_b = TB[1];
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 flush valid", {127'd0, out_valid}, 128'd0);
        chk("R9 flush result", out_res, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 nothing emerges", {127'd0, out_valid}, 128'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule